// File: doc/BRIEF.md
# Eight-Bit I/O Port with Peripheral Pin Override

This block controls eight general-purpose I/O pins from a small register bus. Software sets an output latch, a per-pin direction and a per-pin reduced-drive selection, and reads back both a mixed data view and a pure input view of the pads. Pad inputs pass through a two-stage synchronizer before any readback.

Two attached peripherals can take pins away from software. A pulse-width channel that is enabled forces its pin to output and supplies the pin value. A shutdown control can instead turn pin 7 into an input while its pulse channel is enabled. A serial block, while enabled, owns a parameter-selected subset of pins and sets both their direction and value. Per pin, the serial block wins over the pulse channel, which wins over the direction register. When a peripheral is disabled, the pin reverts to the software registers.

Top module: `gpio_override_port`

## Requirements
- R1: After reset the data, direction and drive registers read 0, and pad_oe_o and pad_rdrv_o are 0.
- R2: Register addresses are 0 for data, 1 for direction, 2 for reduced drive, and 3 for input readback. Reads of addresses 0 to 2 return what was last written. A write to address 3 changes no register and no output.
- R3: For a pin that no peripheral owns, pad_oe_o equals its direction bit (1 means output) and pad_out_o equals its data bit.
- R4: For a pin whose pulse channel is enabled (pwm_en_i bit set), pad_oe_o is 1 and pad_out_o equals pwm_out_i, whatever the direction bit is. This does not apply to pin 7 under R5.
- R5: While pwm_shdn_i is 1 and pulse channel 7 is enabled, pin 7 is an input (pad_oe_o[7]=0, pad_out_o[7]=0). pwm_shdn_i has no effect while pulse channel 7 is disabled.
- R6: While spi_en_i is 1, each pin in SPI_PINS (default 8'h1E, pins 1 to 4) takes pad_oe_o from spi_oe_i and pad_out_o from spi_out_i. This has priority over the pulse channels. Pins outside SPI_PINS are unaffected.
- R7: A pin whose peripheral is disabled returns to direction-register control. spi_oe_i and spi_out_i have no effect while spi_en_i is 0.
- R8: pad_rdrv_o for each pin equals its drive bit while the pin is an output, and is 0 while the pin is an input.
- R9: The input readback (address 3) shows a pad value after the second rising clock edge following the change, and not after the first.
- R10: A data-register read returns the data latch for pins that are currently outputs and the synchronized pad value for pins that are currently inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| pwm_en_i | input | 8 | Per-pin pulse channel enable |
| pwm_out_i | input | 8 | Per-pin pulse channel output value |
| pwm_shdn_i | input | 1 | Shutdown enable, turns pin 7 into an input |
| spi_en_i | input | 1 | Serial block enable |
| spi_out_i | input | 8 | Serial block pin values |
| spi_oe_i | input | 8 | Serial block pin directions |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| pad_rdrv_o | output | 8 | Pad reduced-drive select |

## Verification
The assertions assume that pad_in_i and all peripheral inputs change only between clock edges, away from the sampling edge, and that the bus performs at most one write per cycle. The bench drives every input on the falling edge and holds it for whole cycles. The synchronizer check counts cycles since reset before it compares, so pad values applied during reset do not count against it. Override cases apply their peripheral inputs only after the software registers have settled, so each check sees a single, stable combination.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DRV  = 2'd2,
    SEL_IN   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OWN_SW,
    OWN_PWM,
    OWN_SHDN,
    OWN_SPI
  } pin_owner_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // cycles since reset, saturating at STAGES
  logic [CW-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    age_q <= '0;
    else if (age_q != CW'(STAGES))  age_q <= age_q + 1'b1;

  if (STAGES == 2) begin : g_chk2
    a_r9_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == CW'(STAGES)) |-> (q_o == $past(d_i, 2)));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] oe_eff_i,
  input  logic [WIDTH-1:0] pad_sync_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] drv_o
);
  logic [WIDTH-1:0] data_q, dir_q, drv_q;
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else if (we_i) begin
      unique case (sel)
        SEL_DATA: data_q <= wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_DRV:  drv_q  <= wdata_i;
        default:  ;  // input readback is read-only
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = (data_q & oe_eff_i) | (pad_sync_i & ~oe_eff_i);
      SEL_DIR:  rdata_o = dir_q;
      SEL_DRV:  rdata_o = drv_q;
      default:  rdata_o = pad_sync_i;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign drv_o  = drv_q;

  a_r2_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel == SEL_DIR) |=> $stable(dir_q));
  a_r2_in_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_IN) |=> ($stable(data_q) && $stable(dir_q) && $stable(drv_q)));
  a_r2_data_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_DATA) |=> (data_q == $past(wdata_i)));
endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb
  import gpio_port_pkg::*;
#(
  parameter bit SPI_OWNED = 1'b0,
  parameter bit SHDN_CAP  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic data_i,
  input  logic drv_i,
  input  logic pwm_en_i,
  input  logic pwm_out_i,
  input  logic pwm_shdn_i,
  input  logic spi_en_i,
  input  logic spi_out_i,
  input  logic spi_oe_i,
  output logic oe_o,
  output logic out_o,
  output logic rdrv_o
);
  pin_owner_e owner;

  always_comb begin
    if (SPI_OWNED && spi_en_i)              owner = OWN_SPI;
    else if (pwm_en_i && SHDN_CAP && pwm_shdn_i) owner = OWN_SHDN;
    else if (pwm_en_i)                      owner = OWN_PWM;
    else                                    owner = OWN_SW;
  end

  always_comb begin
    unique case (owner)
      OWN_SPI:  begin oe_o = spi_oe_i; out_o = spi_out_i; end
      OWN_SHDN: begin oe_o = 1'b0;     out_o = 1'b0;      end
      OWN_PWM:  begin oe_o = 1'b1;     out_o = pwm_out_i; end
      default:  begin oe_o = dir_i;    out_o = data_i;    end
    endcase
  end

  assign rdrv_o = drv_i & oe_o;

  a_r8_input_full_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !rdrv_o);
  a_r4_pwm_forces_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && !(SPI_OWNED && spi_en_i) && !(SHDN_CAP && pwm_shdn_i))
      |-> (oe_o && out_o == pwm_out_i));
  a_r6_spi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SPI_OWNED && spi_en_i) |-> (oe_o == spi_oe_i && out_o == spi_out_i));
  if (SHDN_CAP) begin : g_shdn_chk
    a_r5_shdn_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_en_i && pwm_shdn_i && !(SPI_OWNED && spi_en_i)) |-> !oe_o);
  end
  a_r3_sw_control: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_en_i && !(SPI_OWNED && spi_en_i)) |-> (oe_o == dir_i && out_o == data_i));
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] SPI_PINS = 8'h1E,
  parameter int               SHDN_PIN = 7,
  parameter int               SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic [WIDTH-1:0] pwm_en_i,
  input  logic [WIDTH-1:0] pwm_out_i,
  input  logic             pwm_shdn_i,
  input  logic             spi_en_i,
  input  logic [WIDTH-1:0] spi_out_i,
  input  logic [WIDTH-1:0] spi_oe_i,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_rdrv_o
);
  logic [WIDTH-1:0] pad_sync, data_r, dir_r, drv_r;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .oe_eff_i  (pad_oe_o),
    .pad_sync_i(pad_sync),
    .rdata_o   (bus_rdata_o),
    .data_o    (data_r),
    .dir_o     (dir_r),
    .drv_o     (drv_r)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_arb #(
      .SPI_OWNED(SPI_PINS[i]),
      .SHDN_CAP (i == SHDN_PIN)
    ) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dir_i     (dir_r[i]),
      .data_i    (data_r[i]),
      .drv_i     (drv_r[i]),
      .pwm_en_i  (pwm_en_i[i]),
      .pwm_out_i (pwm_out_i[i]),
      .pwm_shdn_i(pwm_shdn_i),
      .spi_en_i  (spi_en_i),
      .spi_out_i (spi_out_i[i]),
      .spi_oe_i  (spi_oe_i[i]),
      .oe_o      (pad_oe_o[i]),
      .out_o     (pad_out_o[i]),
      .rdrv_o    (pad_rdrv_o[i])
    );
  end

  a_r7_spi_off_revert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_en_i && pwm_en_i == '0) |-> (pad_oe_o == dir_r && pad_out_o == data_r));
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (dir_r == '0 && drv_r == '0 && data_r == '0));
endmodule

// File: tb/gpio_override_port_tb.sv
`timescale 1ns/1ps
module gpio_override_port_tb;
  logic       clk = 0, rst_n = 0;
  logic       we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] pwm_en = 0, pwm_out = 0, spi_out = 0, spi_oe = 0, pad_in = 0;
  logic       shdn = 0, spi_en = 0;
  logic [7:0] pad_out, pad_oe, pad_rdrv;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_override_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_en_i(pwm_en),
    .pwm_out_i(pwm_out), .pwm_shdn_i(shdn), .spi_en_i(spi_en),
    .spi_out_i(spi_out), .spi_oe_i(spi_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_rdrv_o(pad_rdrv)
  );

  // [11]dir [10]data [9]drv [8]pwm_en [7]pwm_out [6]shdn [5]spi_en
  // [4]spi_out [3]spi_oe [2]exp_oe [1]exp_out [0]exp_rdrv
  localparam logic [11:0][7:0] VEC [7] = '{
    {8'hA5,8'h3C,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'hA5,8'h3C,8'hA5},
    {8'h00,8'hFF,8'h0F,8'hFF,8'h5A,8'h00,8'h00,8'h00,8'h00,8'hFF,8'h5A,8'h0F},
    {8'hFF,8'h00,8'hF0,8'hFF,8'hFF,8'h01,8'h00,8'h00,8'h00,8'h7F,8'h7F,8'h70},
    {8'h00,8'h00,8'hFF,8'hFF,8'h00,8'h00,8'h01,8'hFF,8'h0A,8'hEB,8'h1E,8'hEB},
    {8'h0F,8'hF0,8'h00,8'h00,8'h00,8'h00,8'h00,8'hFF,8'hFF,8'h0F,8'hF0,8'h00},
    {8'h80,8'h80,8'h80,8'h80,8'h80,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    {8'h80,8'h80,8'h80,8'h00,8'h00,8'h01,8'h00,8'h00,8'h00,8'h80,8'h80,8'h80}
  };
  localparam string VREQ [7] = '{"R3/R8", "R4", "R5", "R6", "R7", "R5", "R5"};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic periph_off();
    pwm_en = 0; pwm_out = 0; shdn = 0; spi_en = 0; spi_out = 0; spi_oe = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd1, r); check("R1 dir", r, 8'h00);
    rd(2'd2, r); check("R1 drv", r, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 rdrv", pad_rdrv, 8'h00);

    // override table
    for (int v = 0; v < 7; v++) begin
      periph_off();
      wr(2'd1, VEC[v][11]);
      wr(2'd0, VEC[v][10]);
      wr(2'd2, VEC[v][9]);
      @(negedge clk);
      pwm_en = VEC[v][8]; pwm_out = VEC[v][7]; shdn = VEC[v][6][0];
      spi_en = VEC[v][5][0]; spi_out = VEC[v][4]; spi_oe = VEC[v][3];
      @(negedge clk); #1;
      check({VREQ[v], " oe"}, pad_oe, VEC[v][2]);
      check({VREQ[v], " out"}, pad_out, VEC[v][1]);
      check({"R8 rdrv ", VREQ[v]}, pad_rdrv, VEC[v][0]);
    end
    periph_off();

    // R2 readback and read-only input register
    wr(2'd1, 8'h0F); wr(2'd0, 8'hAA); wr(2'd2, 8'h33);
    rd(2'd1, r); check("R2 dir read", r, 8'h0F);
    rd(2'd2, r); check("R2 drv read", r, 8'h33);
    wr(2'd3, 8'h55);
    rd(2'd1, r); check("R2 dir after in-write", r, 8'h0F);
    rd(2'd2, r); check("R2 drv after in-write", r, 8'h33);
    rd(2'd3, r); check("R2 in after in-write", r, 8'h00);
    check("R2 oe after in-write", pad_oe, 8'h0F);
    check("R2 out after in-write", pad_out, 8'hAA);

    // R9 synchronizer latency
    @(negedge clk); addr = 2'd3; pad_in = 8'hC3;
    @(posedge clk); #1 check("R9 after 1 edge", rdata, 8'h00);
    @(posedge clk); #1 check("R9 after 2 edges", rdata, 8'hC3);

    // R10 data read mixes latch and pad
    rd(2'd0, r); check("R10 sw dir", r, 8'hCA);
    @(negedge clk); pwm_en = 8'hF0; wr(2'd1, 8'h00);
    rd(2'd0, r); check("R10 pwm owns", r, 8'hA3);
    periph_off();

    // R7 disabling pwm returns to direction bits
    @(negedge clk); #1 check("R7 pwm off oe", pad_oe, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule